// File: doc/BRIEF.md
# Stage-Controlled All-to-All Exchange Sequencer

This block sequences an all-to-all personalized exchange over a multistage shuffle-exchange fabric built from 2x2 switches, where every switch in a stage shares one control bit. The fabric has N terminals and STG = ceil(log2 N) stages. N need not be a power of two. The sequencer issues a configuration tag to all inputs at once, one tag per round. It runs every one of the 2^STG tag values, so each source reaches each destination at least once, whatever N is.

The exchange has two phases. In the first phase, each input injects its own index as a label. The fabric presents, at each output, the label that arrived there. For each source, the sequencer keeps a small queue of the destinations it reached, each stored with the tag that reached it. It keeps only the first arrival for each (source, destination) pair. In the second phase the same tags are issued again. On the round whose tag matches the head entry of a source's queue, that source is told to inject its message for the stored destination. A pulse on `done` marks the moment the last injection has drained through the final stage.

Top module: `allexch_sequencer`

## Requirements
- R1: After reset, `busy`, `done` and `inj_valid` are 0, and every `snd_valid` bit is 0.
- R2: In each phase, `inj_valid` is 1 for the first 2^STG rounds. During those rounds `inj_tag` runs 0, 1, …, 2^STG−1, rising by one each round.
- R3: Each phase lasts 2^STG + STG − 1 rounds, and `round_cnt` counts 0 upward within the phase. `phase_send` is 0 during the first (labelling) phase and 1 during the second (sending) phase.
- R4: `done` is high for exactly one cycle, in the cycle after the final sending-phase round. `busy` is then 0.
- R5: Arrivals are recorded only in labelling-phase rounds STG−1 and later. An arrival in round r is recorded with tag r − (STG−1). Arrivals in earlier rounds have no effect.
- R6: Each source records a destination only the first time it arrives there. A source therefore sends exactly one message to each of the N destinations.
- R7: In sending round r < 2^STG, `snd_valid[s]` is 1 exactly when the head of source s's queue carries tag r. In that case, `snd_dst` field s holds the stored destination, and the entry is removed at the end of the round.
- R8: A `start` pulse, including one given mid-exchange, restarts the labelling phase at tag 0 and empties all queues.
- R9: Arrivals presented during the sending phase change neither the queues nor any sending output.
- R10: Output t carries its label in `arr_src` bits [t*SW +: SW], qualified by `arr_valid[t]`. In any round, at most one output carries a given source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) an exchange |
| arr_valid | input | N | Per-output label-present flag |
| arr_src | input | N*SW | Per-output arriving source label |
| inj_valid | output | 1 | Tag issue round |
| inj_tag | output | STG | Stage configuration tag for all inputs |
| phase_send | output | 1 | 0 labelling phase, 1 sending phase |
| round_cnt | output | RW | Round within current phase |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| snd_valid | output | N | Per-source inject-message flag |
| snd_dst | output | N*SW | Per-source destination of message to inject |

## Verification
The bench models the fabric from the shuffle rule, with each stage bit taken from the tag MSB-first. It feeds outputs the labels reached by the tag issued STG−1 rounds earlier. With six terminals the eight tags force repeated (source, destination) hits, which separates first-arrival recording from naive appending. One run adds a stray permutation in labelling rounds before the capture window and during the sending phase; wrong window or phase gating shows up as shifted or extra sends. A mid-run restart followed by a full exchange tells apart cleared queues from stale entries.

// File: rtl/allexch_pkg.sv
package allexch_pkg;

    typedef enum logic [0:0] {
        PH_LABEL = 1'b0,
        PH_SEND  = 1'b1
    } phase_e;

    // number of tag values needed to cover every stage-control setting
    function automatic int tag_count(input int stages);
        return 1 << stages;
    endfunction

endpackage

// File: rtl/allexch_round_ctrl.sv
module allexch_round_ctrl
    import allexch_pkg::*;
#(
    parameter int STG = 3,
    parameter int RW  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output logic            busy,
    output phase_e          phase,
    output logic [RW-1:0]   round,
    output logic            done,
    output logic            inj_valid,
    output logic [STG-1:0]  inj_tag,
    output logic            cap_en,
    output logic [STG-1:0]  cap_tag,
    output logic            send_en
);
    localparam int NT = tag_count(STG);
    localparam int PL = NT + STG - 1;
    localparam logic [RW-1:0] LAST_R  = RW'(PL - 1);
    localparam logic [RW-1:0] NT_R    = RW'(NT);
    localparam logic [RW-1:0] DRAIN_R = RW'(STG - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            phase <= PH_LABEL;
            round <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy  <= 1'b1;
                phase <= PH_LABEL;
                round <= '0;
            end else if (busy) begin
                if (round == LAST_R) begin
                    round <= '0;
                    if (phase == PH_LABEL) begin
                        phase <= PH_SEND;
                    end else begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    round <= round + 1'b1;
                end
            end
        end
    end

    always_comb begin
        inj_valid = busy && (round < NT_R);
        inj_tag   = round[STG-1:0];
        cap_en    = busy && (phase == PH_LABEL) && (round >= DRAIN_R);
        cap_tag   = STG'(round - DRAIN_R);
        send_en   = busy && (phase == PH_SEND) && (round < NT_R);
    end

    // R2
    tag_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inj_valid && !start && round != LAST_R) |=> (inj_tag == $past(inj_tag) + 1'b1));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R3
    phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && phase == PH_LABEL && round == LAST_R) |=> (phase == PH_SEND && round == '0));

endmodule

// File: rtl/allexch_src_queue.sv
module allexch_src_queue #(
    parameter int N      = 6,
    parameter int SW     = 3,
    parameter int TW     = 3,
    parameter int SRC_ID = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            cap_en,
    input  logic [TW-1:0]   cap_tag,
    input  logic [N-1:0]    arr_valid,
    input  logic [N*SW-1:0] arr_src,
    input  logic            send_en,
    input  logic [TW-1:0]   send_tag,
    output logic            snd_valid,
    output logic [SW-1:0]   snd_dst
);
    localparam int PW = $clog2(N + 1);
    localparam logic [PW-1:0] FULL = PW'(N);

    logic [SW-1:0] q_dst [N];
    logic [TW-1:0] q_tag [N];
    logic [N-1:0]  seen;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [N-1:0]  hits;
    logic          hit_any;
    logic [SW-1:0] hit_idx;
    logic          push, pop, nonempty;

    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int t = 0; t < N; t++) begin
            hits[t] = arr_valid[t] && (arr_src[t*SW +: SW] == SW'(SRC_ID));
        end
        for (int t = N - 1; t >= 0; t--) begin
            if (hits[t]) begin
                hit_any = 1'b1;
                hit_idx = SW'(t);
            end
        end
    end

    always_comb begin
        push      = cap_en && hit_any && !seen[hit_idx] && (wr_ptr != FULL);
        nonempty  = rd_ptr < wr_ptr;
        snd_valid = send_en && nonempty && (q_tag[rd_ptr] == send_tag);
        snd_dst   = snd_valid ? q_dst[rd_ptr] : '0;
        pop       = snd_valid;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            seen   <= '0;
        end else begin
            if (push) begin
                q_dst[wr_ptr]  <= hit_idx;
                q_tag[wr_ptr]  <= cap_tag;
                seen[hit_idx]  <= 1'b1;
                wr_ptr         <= wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    // R10
    one_port_per_src_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(hits) <= 1);

    // R6
    queue_bound_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ptr <= FULL);

    // R7
    head_not_stale_chk: assert property (@(posedge clk) disable iff (rst)
        (send_en && nonempty) |-> (q_tag[rd_ptr] >= send_tag));

    // R9
    no_push_in_send_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && !clear) |=> $stable(wr_ptr));

endmodule

// File: rtl/allexch_sequencer.sv
module allexch_sequencer
    import allexch_pkg::*;
#(
    parameter int N   = 6,
    parameter int SW  = $clog2(N),
    parameter int STG = $clog2(N),
    parameter int RW  = $clog2(tag_count(STG) + STG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [N-1:0]    arr_valid,
    input  logic [N*SW-1:0] arr_src,
    output logic            inj_valid,
    output logic [STG-1:0]  inj_tag,
    output logic            phase_send,
    output logic [RW-1:0]   round_cnt,
    output logic            busy,
    output logic            done,
    output logic [N-1:0]    snd_valid,
    output logic [N*SW-1:0] snd_dst
);
    phase_e          phase;
    logic            cap_en, send_en;
    logic [STG-1:0]  cap_tag;

    allexch_round_ctrl #(.STG(STG), .RW(RW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .busy      (busy),
        .phase     (phase),
        .round     (round_cnt),
        .done      (done),
        .inj_valid (inj_valid),
        .inj_tag   (inj_tag),
        .cap_en    (cap_en),
        .cap_tag   (cap_tag),
        .send_en   (send_en)
    );

    assign phase_send = (phase == PH_SEND);

    for (genvar s = 0; s < N; s++) begin : g_src
        allexch_src_queue #(.N(N), .SW(SW), .TW(STG), .SRC_ID(s)) u_q (
            .clk       (clk),
            .rst       (rst),
            .clear     (start),
            .cap_en    (cap_en),
            .cap_tag   (cap_tag),
            .arr_valid (arr_valid),
            .arr_src   (arr_src),
            .send_en   (send_en),
            .send_tag  (inj_tag),
            .snd_valid (snd_valid[s]),
            .snd_dst   (snd_dst[s*SW +: SW])
        );
    end

    // R7
    send_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        (|snd_valid) |-> (busy && phase_send && inj_valid));

endmodule

// File: tb/allexch_sequencer_tb.sv
`timescale 1ns/1ps
module allexch_sequencer_tb;
    localparam int N   = 6;
    localparam int SW  = $clog2(N);
    localparam int STG = $clog2(N);
    localparam int NT  = 1 << STG;
    localparam int PL  = NT + STG - 1;
    localparam int RW  = $clog2(NT + STG);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [N-1:0]    arr_valid = '0;
    logic [N*SW-1:0] arr_src = '0;
    logic            inj_valid, phase_send, busy, done;
    logic [STG-1:0]  inj_tag;
    logic [RW-1:0]   round_cnt;
    logic [N-1:0]    snd_valid;
    logic [N*SW-1:0] snd_dst;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    allexch_sequencer #(.N(N)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .arr_valid(arr_valid), .arr_src(arr_src),
        .inj_valid(inj_valid), .inj_tag(inj_tag), .phase_send(phase_send),
        .round_cnt(round_cnt), .busy(busy), .done(done),
        .snd_valid(snd_valid), .snd_dst(snd_dst)
    );

    function automatic int route(input int tag, input int src);
        int p = src;
        for (int j = 0; j < STG; j++) begin
            p = (2 * p + (2 * p) / N) % N;
            if ((tag >> (STG - 1 - j)) & 1) p = p ^ 1;
        end
        return p;
    endfunction

    function automatic int first_tag(input int s, input int t);
        for (int x = 0; x < NT; x++) if (route(x, s) == t) return x;
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_perm(input int tag, input bit en);
        for (int s = 0; s < N; s++) begin
            arr_src[route(tag, s)*SW +: SW] = SW'(s);
        end
        arr_valid = en ? '1 : '0;
    endtask

    // one full exchange; stray=1 adds out-of-window arrivals (R5, R9)
    task automatic run_exchange(input bit stray);
        int sent [N];
        for (int s = 0; s < N; s++) sent[s] = 0;
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        for (int ph = 0; ph < 2; ph++) begin
            for (int k = 0; k < PL; k++) begin
                @(negedge clk);
                start = 1'b0;
                check(busy == 1'b1, "R3 busy", busy, 1);
                check(phase_send == ph[0], "R3 phase", phase_send, ph);
                check(round_cnt == RW'(k), "R3 round", round_cnt, k);
                check(inj_valid == (k < NT), "R2 inj_valid", inj_valid, k < NT);
                if (k < NT) check(inj_tag == STG'(k), "R2 tag", inj_tag, k);
                check(done == 1'b0, "R4 early done", done, 0);
                if (ph == 0) begin
                    if (k >= STG - 1) drive_perm(k - (STG - 1), 1'b1);
                    else drive_perm(3, stray);
                    check(snd_valid == '0, "R7 no send in labelling", snd_valid, 0);
                end else begin
                    drive_perm(k % NT, stray);
                    for (int s = 0; s < N; s++) begin
                        int t = (k < NT) ? route(k, s) : 0;
                        bit ev = (k < NT) && (first_tag(s, t) == k);
                        check(snd_valid[s] == ev, "R7 snd_valid", snd_valid[s], ev);
                        if (ev) begin
                            check(snd_dst[s*SW +: SW] == SW'(t), "R7 snd_dst", snd_dst[s*SW +: SW], t);
                            sent[s]++;
                        end
                    end
                end
            end
        end
        @(negedge clk);
        arr_valid = '0;
        check(done == 1'b1, "R4 done pulse", done, 1);
        check(busy == 1'b0, "R4 idle at done", busy, 0);
        for (int s = 0; s < N; s++) check(sent[s] == N, "R6 one per dest", sent[s], N);
        @(negedge clk);
        check(done == 1'b0, "R4 done width", done, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(inj_valid == 1'b0, "R1 inj_valid", inj_valid, 0);
        check(snd_valid == '0, "R1 snd_valid", snd_valid, 0);
    endtask

    task automatic t_restart();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < PL; k++) begin
            drive_perm((k + 5) % NT, 1'b1);
            @(negedge clk);
        end
        drive_perm(1, 1'b1);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        arr_valid = '0;
        check(phase_send == 1'b0, "R8 phase after restart", phase_send, 0);
        check(inj_tag == '0 && inj_valid, "R8 tag after restart", inj_tag, 0);
        check(round_cnt == '0, "R8 round after restart", round_cnt, 0);
        run_exchange(1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        run_exchange(1'b0);
        run_exchange(1'b1);
        t_restart();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule